// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block owns the status register of a small serial nonvolatile memory and rules on every write that the command decoder wants to start. A write of the status register or of the memory array goes ahead only when the write-enable latch is set, no internal write is already running, and the protection settings allow it. Protection has two layers. A two-bit region selector fences off an upper part of the array. A hardware lock, formed by a low write-protect pin together with a set lock-enable bit, freezes the status register, and therefore freezes the lock-enable bit itself for as long as the pin stays low.

A granted write starts a fixed-length internal write. The write-in-progress flag reads 1 while it runs. When it finishes, the write-enable latch is cleared, and a status-register write has its new protection bits committed at that moment. A refused write changes nothing. The command decoder raises the latch-set strobe after a write-enable command, presents requests with their data byte or 14-bit address, and reads the status byte back for the status-read command. Storage of the nonvolatile bits is modelled with ordinary flops.

Top module: `spm_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and both grant outputs are low.
- R2: The status byte holds write-in-progress at bit 0, the write-enable latch at bit 1, the region selector at bits 3:2 and the lock-enable bit at bit 7. Bits 6:4 read 0. The hardware lock is active exactly when `wp_pin` is 0 and bit 7 is 1. While it is active every status-register write is refused, including one that would clear bit 7.
- R3: While the hardware lock is active, an array write to an address outside the protected region is granted when the latch is 1.
- R4: While the hardware lock is inactive, a status-register write is granted when the latch is 1 and refused when it is 0.
- R5: The protected region follows bits 3:2: 00 protects nothing, 01 protects 0x3000 to 0x3FFF, 10 protects 0x2000 to 0x3FFF and 11 protects the whole array. An array write inside the region is never granted, whatever the pin or the lock-enable bit.
- R6: A status-register write whose data has any of bits 0, 1, 4, 5 or 6 set is refused.
- R7: A grant is a one-cycle pulse in the cycle after the request. Bit 0 of the status byte reads 1 from that cycle for exactly WRITE_CYCLES cycles.
- R8: Any write request made while bit 0 is 1 is refused.
- R9: A refused write leaves the whole status byte unchanged, the latch included.
- R10: When a granted write completes, the latch clears. After a granted status-register write, bits 7 and 3:2 take the values of data bits 7 and 3:2.
- R11: When a status-register request and an array request arrive in the same cycle, the status-register request is decided alone and the array request is refused.
- R12: A latch-set strobe sets bit 1 in the next cycle while no write is in progress. A strobe made while a write is in progress is ignored, including in the write's final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_pin | input | 1 | Hardware write-protect pin, low asserts protection |
| wel_set | input | 1 | Strobe from a decoded write-enable command |
| sr_wr_req | input | 1 | Status-register write request, one cycle |
| sr_wr_data | input | 8 | Data byte for the status-register write |
| arr_wr_req | input | 1 | Array write request, one cycle |
| arr_wr_addr | input | ADDR_W | Target address of the array write |
| sr_wr_grant | output | 1 | Status-register write accepted, one-cycle pulse |
| arr_wr_grant | output | 1 | Array write accepted, one-cycle pulse |
| status_o | output | 8 | Status byte for readback |

## Verification
Assertions check on every cycle that no grant comes out while the hardware lock is active for the status register, while the address is in the protected region, while the latch is clear, while a write is running, or for a data byte with a reserved bit set. They also check that the two grants never coincide, that the latch is clear after every completion, and that the protection bits move only at a completion. Only the bench's scenarios can show the allowed side: that each combination of pin, lock-enable bit, latch and region selector grants exactly the writes it should, that each boundary address of every region setting falls on the correct side, that the busy window lasts exactly WRITE_CYCLES cycles, and that a latch-set strobe in the final busy cycle is lost.

// File: rtl/spm_wp_pkg.sv
package spm_wp_pkg;

  localparam int SR_W      = 8;
  localparam int SR_WIP    = 0;
  localparam int SR_WEL    = 1;
  localparam int SR_BP_LO  = 2;
  localparam int SR_BP_HI  = 3;
  localparam int SR_LOCK   = 7;

  // Bits a status-register write must leave at zero.
  localparam logic [SR_W-1:0] SR_RSVD_MASK = 8'b0111_0011;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_t;

  typedef struct packed {
    logic lock_en;
    bp_t  bp;
  } sr_nv_t;

  function automatic logic [SR_W-1:0] pack_status(input sr_nv_t nv, input logic wel,
                                                  input logic wip);
    logic [SR_W-1:0] s;
    s           = '0;
    s[SR_LOCK]  = nv.lock_en;
    s[SR_BP_HI] = nv.bp[1];
    s[SR_BP_LO] = nv.bp[0];
    s[SR_WEL]   = wel;
    s[SR_WIP]   = wip;
    return s;
  endfunction

endpackage

// File: rtl/spm_wp_region.sv
module spm_wp_region
  import spm_wp_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  bp_t               bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_region
);

  localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);

  logic above_quarter;
  logic above_half;

  always_comb begin
    above_quarter = (addr >= QUARTER_BASE);
    above_half    = (addr >= HALF_BASE);
    unique case (bp)
      BP_NONE:    in_region = 1'b0;
      BP_QUARTER: in_region = above_quarter;
      BP_HALF:    in_region = above_half;
      BP_ALL:     in_region = 1'b1;
      default:    in_region = 1'b1;
    endcase
  end

endmodule

// File: rtl/spm_wp_arbiter.sv
module spm_wp_arbiter
  import spm_wp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wp_pin,
  input  logic            lock_en,
  input  logic            wel,
  input  logic            busy,
  input  logic            sr_req,
  input  logic [SR_W-1:0] sr_data,
  input  logic            arr_req,
  input  logic            addr_in_region,
  output logic            start_sr,
  output logic            start_arr,
  output logic            sr_grant,
  output logic            arr_grant
);

  logic hw_lock;
  logic data_clean;
  logic may_start;
  logic sr_grant_d;
  logic arr_grant_d;
  logic sr_grant_q;
  logic arr_grant_q;

  always_comb begin
    hw_lock     = ~wp_pin & lock_en;
    data_clean  = ((sr_data & SR_RSVD_MASK) == '0);
    may_start   = wel & ~busy;
    start_sr    = sr_req & may_start & ~hw_lock & data_clean;
    // A status-register request claims the cycle even when it is refused.
    start_arr   = arr_req & ~sr_req & may_start & ~addr_in_region;
    sr_grant_d  = start_sr;
    arr_grant_d = start_arr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_grant_q  <= 1'b0;
      arr_grant_q <= 1'b0;
    end else begin
      sr_grant_q  <= sr_grant_d;
      arr_grant_q <= arr_grant_d;
    end
  end

  assign sr_grant  = sr_grant_q;
  assign arr_grant = arr_grant_q;

  p_sr_grant_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant_q |-> ($past(wp_pin) || !$past(lock_en)));

  p_sr_grant_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant_q || arr_grant_q) |-> $past(wel));

  p_sr_grant_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant_q |-> (($past(sr_data) & SR_RSVD_MASK) == '0));

  p_arr_grant_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant_q |-> !$past(addr_in_region));

  p_grant_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant_q || arr_grant_q) |-> !$past(busy));

  p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_grant_q && arr_grant_q));

endmodule

// File: rtl/spm_wp_timer.sv
module spm_wp_timer #(
  parameter int WRITE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    busy   = (cnt_q != '0);
    done   = (cnt_q == CNT_ONE);
    cnt_en = start | busy;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_d = CNT_LOAD;
    end else if (busy) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_start_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/spm_wp_status.sv
module spm_wp_status
  import spm_wp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wel_set,
  input  logic            busy,
  input  logic            start_sr,
  input  logic [SR_W-1:0] sr_data,
  input  logic            done,
  output sr_nv_t          nv,
  output logic            wel
);

  sr_nv_t nv_q;
  sr_nv_t nv_d;
  logic   nv_en;
  sr_nv_t pend_q;
  sr_nv_t pend_d;
  logic   pend_vld_q;
  logic   pend_vld_d;
  logic   pend_en;
  logic   wel_q;
  logic   wel_d;
  logic   wel_en;

  always_comb begin
    pend_en        = start_sr | done;
    pend_d.lock_en = sr_data[SR_LOCK];
    pend_d.bp      = bp_t'(sr_data[SR_BP_HI:SR_BP_LO]);
    pend_vld_d     = start_sr;

    nv_en = done & pend_vld_q;
    nv_d  = pend_q;

    // Completion clears; a strobe is honoured only while idle.
    wel_en = done | (wel_set & ~busy);
    wel_d  = ~done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else if (pend_en) begin
      if (start_sr) begin
        pend_q <= pend_d;
      end
      pend_vld_q <= pend_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q <= '0;
    end else if (nv_en) begin
      nv_q <= nv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (wel_en) begin
      wel_q <= wel_d;
    end
  end

  assign nv  = nv_q;
  assign wel = wel_q;

  p_wel_clear_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wel_q);

  p_nv_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(nv_q));

  p_wel_set_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_set && !busy) |=> wel_q);

endmodule

// File: rtl/spm_wp_ctrl.sv
module spm_wp_ctrl
  import spm_wp_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int WRITE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              wel_set,
  input  logic              sr_wr_req,
  input  logic [7:0]        sr_wr_data,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_wr_addr,
  output logic              sr_wr_grant,
  output logic              arr_wr_grant,
  output logic [7:0]        status_o
);

  logic   rst_meta_q;
  logic   rst_sync_q;
  logic   busy;
  logic   done;
  logic   wel;
  sr_nv_t nv;
  logic   in_region;
  logic   start_sr;
  logic   start_arr;
  logic   start_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  spm_wp_region #(.ADDR_W(ADDR_W)) u_region (
    .bp        (nv.bp),
    .addr      (arr_wr_addr),
    .in_region (in_region)
  );

  spm_wp_arbiter u_arbiter (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .wp_pin         (wp_pin),
    .lock_en        (nv.lock_en),
    .wel            (wel),
    .busy           (busy),
    .sr_req         (sr_wr_req),
    .sr_data        (sr_wr_data),
    .arr_req        (arr_wr_req),
    .addr_in_region (in_region),
    .start_sr       (start_sr),
    .start_arr      (start_arr),
    .sr_grant       (sr_wr_grant),
    .arr_grant      (arr_wr_grant)
  );

  assign start_any = start_sr | start_arr;

  spm_wp_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (start_any),
    .busy  (busy),
    .done  (done)
  );

  spm_wp_status u_status (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wel_set  (wel_set),
    .busy     (busy),
    .start_sr (start_sr),
    .sr_data  (sr_wr_data),
    .done     (done),
    .nv       (nv),
    .wel      (wel)
  );

  assign status_o = pack_status(nv, wel, busy);

  p_wip_on_grant_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (sr_wr_grant || arr_wr_grant) |-> status_o[SR_WIP]);

  p_grant_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (sr_wr_grant || arr_wr_grant) |=> !(sr_wr_grant || arr_wr_grant));

endmodule

// File: tb/spm_wp_ctrl_bench.sv
`timescale 1ns/1ps
module spm_wp_ctrl_bench;

  localparam int AW = 14;
  localparam int WC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wp_pin;
  logic          wel_set;
  logic          sr_wr_req;
  logic [7:0]    sr_wr_data;
  logic          arr_wr_req;
  logic [AW-1:0] arr_wr_addr;
  logic          sr_wr_grant;
  logic          arr_wr_grant;
  logic [7:0]    status_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  spm_wp_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u_spm_wp_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_pin       (wp_pin),
    .wel_set      (wel_set),
    .sr_wr_req    (sr_wr_req),
    .sr_wr_data   (sr_wr_data),
    .arr_wr_req   (arr_wr_req),
    .arr_wr_addr  (arr_wr_addr),
    .sr_wr_grant  (sr_wr_grant),
    .arr_wr_grant (arr_wr_grant),
    .status_o     (status_o)
  );

  typedef struct packed {
    logic          pin;
    logic          lock;
    logic [1:0]    bp;
    logic          wel;
    logic          is_sr;
    logic [7:0]    data;
    logic [AW-1:0] addr;
    logic          exp_grant;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 8'h00, 14'h0000, 1'b0, 4'd2},  // R2 lock clear refused
    '{1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 8'h84, 14'h0000, 1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 8'h00, 14'h3FFF, 1'b0, 4'd5},  // R5 locked and in region
    '{1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 8'h00, 14'h0000, 1'b1, 4'd3},  // R3
    '{1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 8'h00, 14'h1FFF, 1'b1, 4'd3},  // R3
    '{1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 8'h0C, 14'h0000, 1'b1, 4'd4},  // R4 pin high
    '{1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 8'h84, 14'h0000, 1'b1, 4'd4},  // R4 enable bit clear
    '{1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 8'h04, 14'h0000, 1'b0, 4'd4},  // R4 latch clear
    '{1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 8'h05, 14'h0000, 1'b0, 4'd6},  // R6 bit 0
    '{1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 8'h10, 14'h0000, 1'b0, 4'd6},  // R6 bit 4
    '{1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 8'h42, 14'h0000, 1'b0, 4'd6},  // R6 bits 6,1
    '{1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 8'h00, 14'h2000, 1'b0, 4'd5},  // R5 half edge
    '{1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 8'h00, 14'h3000, 1'b0, 4'd5},  // R5 quarter edge
    '{1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 8'h00, 14'h2FFF, 1'b1, 4'd5},  // R5 below quarter
    '{1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 8'h00, 14'h0000, 1'b0, 4'd5},  // R5 all
    '{1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 14'h3FFF, 1'b0, 4'd9}   // R9 latch clear
  };

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_wel();
    wel_set = 1'b1;
    @(negedge clk);
    wel_set = 1'b0;
  endtask

  task automatic issue(input logic sr, input logic arr, input logic [7:0] d,
                       input logic [AW-1:0] a, output logic gs, output logic ga);
    sr_wr_req   = sr;
    arr_wr_req  = arr;
    sr_wr_data  = d;
    arr_wr_addr = a;
    @(negedge clk);
    sr_wr_req  = 1'b0;
    arr_wr_req = 1'b0;
    gs = sr_wr_grant;
    ga = arr_wr_grant;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (status_o[0] && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic setup_sr(input logic lock, input logic [1:0] bp);
    logic gs, ga;
    wp_pin = 1'b1;
    pulse_wel();
    issue(1'b1, 1'b0, {lock, 3'b000, bp, 2'b00}, '0, gs, ga);
    wait_idle();
  endtask

  initial begin
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    logic gs, ga, g;
    logic [7:0] exp_s;
    int n;
    rst_n       = 1'b0;
    wp_pin      = 1'b1;
    wel_set     = 1'b0;
    sr_wr_req   = 1'b0;
    sr_wr_data  = '0;
    arr_wr_req  = 1'b0;
    arr_wr_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(status_o == 8'h00, "R1 status", 16'(status_o), 16'h00);
    check(!sr_wr_grant && !arr_wr_grant, "R1 grants",
          16'({sr_wr_grant, arr_wr_grant}), 16'h0);

    // R12 latch set while idle
    pulse_wel();
    check(status_o == 8'h02, "R12 latch set", 16'(status_o), 16'h02);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      setup_sr(VECS[i].lock, VECS[i].bp);
      wp_pin = VECS[i].pin;
      if (VECS[i].wel) pulse_wel();
      issue(VECS[i].is_sr, !VECS[i].is_sr, VECS[i].data, VECS[i].addr, gs, ga);
      g = VECS[i].is_sr ? gs : ga;
      n_tests++;
      if (g !== VECS[i].exp_grant || (gs && ga)) begin
        n_fail++;
        $display("FAIL R%0d vec %0d grant actual=%0b expected=%0b", VECS[i].req, i, g,
                 VECS[i].exp_grant);
      end
      wait_idle();
      if (VECS[i].exp_grant && VECS[i].is_sr)
        exp_s = {VECS[i].data[7], 3'b000, VECS[i].data[3:2], 2'b00};
      else
        exp_s = {VECS[i].lock, 3'b000, VECS[i].bp, VECS[i].wel & ~VECS[i].exp_grant, 1'b0};
      n_tests++;
      if (status_o !== exp_s) begin
        n_fail++;
        $display("FAIL R%0d vec %0d status actual=0x%0h expected=0x%0h (R9/R10)",
                 VECS[i].req, i, status_o, exp_s);
      end
    end

    // R7 busy window length and single-cycle grant
    setup_sr(1'b0, 2'b00);
    pulse_wel();
    issue(1'b0, 1'b1, 8'h00, 14'h0100, gs, ga);
    check(ga == 1'b1, "R7 grant", 16'(ga), 16'h1);
    @(negedge clk);
    check(arr_wr_grant == 1'b0, "R7 grant pulse width", 16'(arr_wr_grant), 16'h0);
    n = 1;
    while (status_o[0] && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == WC, "R7 wip cycles", 16'(n), 16'(WC));
    check(status_o == 8'h00, "R10 latch cleared", 16'(status_o), 16'h00);

    // R8 request while busy refused
    pulse_wel();
    issue(1'b0, 1'b1, 8'h00, 14'h0000, gs, ga);
    issue(1'b0, 1'b1, 8'h00, 14'h0001, gs, ga);
    check(ga == 1'b0, "R8 array while busy", 16'(ga), 16'h0);
    issue(1'b1, 1'b0, 8'h0C, 14'h0000, gs, ga);
    check(gs == 1'b0, "R8 status while busy", 16'(gs), 16'h0);
    wait_idle();
    check(status_o == 8'h00, "R8 status unchanged", 16'(status_o), 16'h00);

    // R12 strobe in the final busy cycle is ignored
    pulse_wel();
    issue(1'b0, 1'b1, 8'h00, 14'h0000, gs, ga);
    repeat (WC - 1) @(negedge clk);
    pulse_wel();
    check(status_o == 8'h00, "R12 strobe in final busy cycle", 16'(status_o), 16'h00);

    // R11 simultaneous requests
    pulse_wel();
    issue(1'b1, 1'b1, 8'h08, 14'h0000, gs, ga);
    check(gs == 1'b1 && ga == 1'b0, "R11 status first",
          16'({gs, ga}), 16'h2);
    wait_idle();
    check(status_o == 8'h08, "R11 status committed", 16'(status_o), 16'h08);

    // R11 refused status request still blocks array request
    pulse_wel();
    issue(1'b1, 1'b1, 8'h01, 14'h0000, gs, ga);
    check(gs == 1'b0 && ga == 1'b0, "R11 both refused", 16'({gs, ga}), 16'h0);
    check(status_o == 8'h0A, "R9 after refused pair", 16'(status_o), 16'h0A);

    // R2 lock holds while pin low; releasing the pin allows clearing it
    setup_sr(1'b1, 2'b00);
    wp_pin = 1'b0;
    pulse_wel();
    issue(1'b1, 1'b0, 8'h00, 14'h0000, gs, ga);
    check(gs == 1'b0, "R2 lock clear refused", 16'(gs), 16'h0);
    wp_pin = 1'b1;
    issue(1'b1, 1'b0, 8'h00, 14'h0000, gs, ga);
    check(gs == 1'b1, "R2 unlock with pin high", 16'(gs), 16'h1);
    wait_idle();
    check(status_o == 8'h00, "R2 lock cleared", 16'(status_o), 16'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule